// File: doc/BRIEF.md
# Atomic Read-Modify-Write Lock Unit

This unit sits between several cores and a single shared memory port and carries out locked read-modify-write operations on their behalf. A core posts a request made of an opcode (bit test-and-set, bit test-and-reset, decrement or exchange), a word address, an operand (the bit index for the bit operations, the new value for exchange) and the current emptiness of its own store buffer. The unit picks one requester and gives it exclusive ownership of memory. It then stalls every other core, reads the word, writes the modified word in the very next cycle, and waits for the owner's store buffer to drain. Only then does it release the lock and return the previous value with a carry flag and a sign flag.

Software builds spinlocks on these flags. It either loops on the carry returned by test-and-set, or decrements a counter and tests the sign. Waiting for the owner's store buffer before release makes each atomic operation behave as a full memory fence for that core. A core that asks while another holds the lock simply waits and is served after the release. When several cores ask in the same cycle, the unit grants them in round-robin order.

Requester protocol: a core holds its request valid until it sees its grant pulse, drops it in the following cycle, and waits for its response pulse.

Top module: `atomic_lock_unit`

## Requirements
- R1: Opcode 0 (bit test-and-set) returns bit operand[IDX_W-1:0] of the old word as carry and writes the word back with that bit set to 1.
- R2: Opcode 1 (bit test-and-reset) returns the selected bit of the old word as carry and writes the word back with that bit cleared to 0.
- R3: Opcode 2 (decrement) writes back the old word minus one, wrapping at zero. Carry is 1 exactly when the old word was zero.
- R4: Opcode 3 (exchange) writes the operand into the word with carry 0. For every opcode, sign equals the most significant bit of the written word.
- R5: The response is a one-cycle pulse on the owner's rsp_valid bit. rsp_old, rsp_carry and rsp_sign are valid in that same cycle, and rsp_old equals the word read from memory.
- R6: From the cycle of the grant pulse until the cycle before the response pulse, core_stall is 1 for every core except the owner and 0 for the owner. core_stall is all zero while the unit is idle.
- R7: The memory read comes in the cycle of the grant pulse. The write to the same address comes in the next cycle, and no other core is granted in between.
- R8: The lock is not released while the owner's sb_empty is 0. The response pulse comes one cycle after the first cycle in the drain phase where sb_empty of the owner is 1.
- R9: Among simultaneous requests, the first core after the most recently granted one (in increasing index order, wrapping) wins. After reset, core 0 has the highest priority.
- R10: A request posted while another core holds the lock is granted in the cycle right after the holder's response pulse.
- R11: After reset, req_grant, rsp_valid, core_stall, mem_rd_en and mem_wr_en are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_CORES | Per-core atomic request |
| req_op | input | 2*NUM_CORES | Per-core opcode (0 set bit, 1 clear bit, 2 decrement, 3 exchange) |
| req_addr | input | ADDR_W*NUM_CORES | Per-core word address |
| req_operand | input | DATA_W*NUM_CORES | Per-core bit index or exchange value |
| sb_empty | input | NUM_CORES | Per-core store buffer empty |
| req_grant | output | NUM_CORES | One-cycle pulse: request accepted, lock taken |
| rsp_valid | output | NUM_CORES | One-cycle pulse: operation complete, lock released |
| rsp_old | output | DATA_W | Word value before the operation |
| rsp_carry | output | 1 | Carry flag of the operation |
| rsp_sign | output | 1 | Sign flag (MSB of the written word) |
| core_stall | output | NUM_CORES | Per-core memory traffic stall |
| mem_rd_en | output | 1 | Memory read strobe, data returned next cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after mem_rd_en |

## Verification
The bench builds the unit with three cores, 16-bit words and a 4-bit address. Three cores let one burst of simultaneous requests expose the full rotating order. With only two cores, a wrong pointer update can pass unnoticed. The 16-bit width puts the sign bit at bit 15 and the decrement wrap at 0xFFFF, so both can be reached with short constants. Holding one core's store buffer non-empty for several cycles while a second core waits shows that the release, the stall and the hand-over all move together.

// File: rtl/atomic_lock_pkg.sv
// Shared opcode and controller state encodings for the atomic lock unit.
// Assumes two opcode bits; encodings are visible at the request port.
package atomic_lock_pkg;
    typedef enum logic [1:0] {
        AOP_BTS  = 2'd0,
        AOP_BTR  = 2'd1,
        AOP_DEC  = 2'd2,
        AOP_XCHG = 2'd3
    } aop_e;

    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_READ   = 2'd1,
        LK_MODIFY = 2'd2,
        LK_DRAIN  = 2'd3
    } lk_state_e;
endpackage

// File: rtl/atomic_rmw_alu.sv
// Combinational modify stage: computes the word to write back and the
// carry and sign flags from the old word, the opcode and the operand.
// Assumes DATA_W is a power of two so the bit index covers the word.
module atomic_rmw_alu
    import atomic_lock_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  aop_e              op,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] new_val,
    output logic              carry,
    output logic              sign
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] bit_mask;
    logic              bit_old;

    // Select the addressed bit for the bit operations
    always_comb begin
        bit_idx  = operand[IDX_W-1:0];
        bit_mask = DATA_W'(1) << bit_idx;
        bit_old  = |(old_val & bit_mask);
    end

    // Produce the write-back word and flags per opcode
    always_comb begin
        unique case (op)
            AOP_BTS: begin
                new_val = old_val | bit_mask;
                carry   = bit_old;
            end
            AOP_BTR: begin
                new_val = old_val & ~bit_mask;
                carry   = bit_old;
            end
            AOP_DEC: begin
                new_val = old_val - DATA_W'(1);
                carry   = (old_val == '0);
            end
            default: begin
                new_val = operand;
                carry   = 1'b0;
            end
        endcase
        sign = new_val[DATA_W-1];
    end
endmodule

// File: rtl/lock_rr_arb.sv
// Round-robin arbiter: grants one requester, starting the search at the
// core after the last one granted. The pointer moves only when advance
// is high and a grant is made. After reset core 0 is searched first.
module lock_rr_arb #(
    parameter int NUM_CORES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] req,
    input  logic                 advance,
    output logic [NUM_CORES-1:0] gnt,
    output logic [(NUM_CORES > 1 ? $clog2(NUM_CORES) : 1)-1:0] gnt_idx
);
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    logic [CORE_W-1:0] last_q;

    // Search requesters in rotating order from last_q + 1
    always_comb begin
        logic found;
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < NUM_CORES; k++) begin
            int c;
            c = (int'(last_q) + 1 + k) % NUM_CORES;
            if (!found && req[c]) begin
                gnt[c]  = 1'b1;
                gnt_idx = CORE_W'(c);
                found   = 1'b1;
            end
        end
    end

    // Remember the winner so it gets lowest priority next time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= CORE_W'(NUM_CORES - 1);
        end else if (advance && (|gnt)) begin
            last_q <= gnt_idx;
        end
    end

    // R9
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R9
    gnt_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt));
endmodule

// File: rtl/atomic_lock_unit.sv
// Top of the atomic lock unit. One lock is shared by all cores. The
// controller walks IDLE -> READ -> MODIFY -> DRAIN: it grants a core,
// issues the read, issues the write in the following cycle using the
// returned data, then holds the lock until the owner's store buffer is
// empty. Non-owners are stalled for the whole hold time.
// Assumes the memory returns read data exactly one cycle after mem_rd_en
// and that a requester drops req_valid after seeing its grant.
module atomic_lock_unit
    import atomic_lock_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES-1:0]        req_valid,
    input  logic [2*NUM_CORES-1:0]      req_op,
    input  logic [ADDR_W*NUM_CORES-1:0] req_addr,
    input  logic [DATA_W*NUM_CORES-1:0] req_operand,
    input  logic [NUM_CORES-1:0]        sb_empty,
    output logic [NUM_CORES-1:0]        req_grant,
    output logic [NUM_CORES-1:0]        rsp_valid,
    output logic [DATA_W-1:0]           rsp_old,
    output logic                        rsp_carry,
    output logic                        rsp_sign,
    output logic [NUM_CORES-1:0]        core_stall,
    output logic                        mem_rd_en,
    output logic                        mem_wr_en,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic [DATA_W-1:0]           mem_rdata
);
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam int OP_W   = 2;

    lk_state_e             state_q;
    logic [CORE_W-1:0]     holder_q;
    aop_e                  op_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [DATA_W-1:0]     operand_q;
    logic [DATA_W-1:0]     old_q;
    logic                  carry_q;
    logic                  sign_q;
    logic [NUM_CORES-1:0]  grant_q;
    logic [NUM_CORES-1:0]  rsp_q;

    logic [NUM_CORES-1:0]  arb_gnt;
    logic [CORE_W-1:0]     arb_idx;
    logic                  in_idle;
    logic [DATA_W-1:0]     alu_new;
    logic                  alu_carry;
    logic                  alu_sign;

    assign in_idle = (state_q == LK_IDLE);

    lock_rr_arb #(
        .NUM_CORES (NUM_CORES)
    ) i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .advance (in_idle),
        .gnt     (arb_gnt),
        .gnt_idx (arb_idx)
    );

    atomic_rmw_alu #(
        .DATA_W (DATA_W)
    ) i_alu (
        .op      (op_q),
        .old_val (mem_rdata),
        .operand (operand_q),
        .new_val (alu_new),
        .carry   (alu_carry),
        .sign    (alu_sign)
    );

    // Lock controller: capture request, sequence read/write, wait for drain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LK_IDLE;
            holder_q  <= '0;
            op_q      <= AOP_BTS;
            addr_q    <= '0;
            operand_q <= '0;
            old_q     <= '0;
            carry_q   <= 1'b0;
            sign_q    <= 1'b0;
            grant_q   <= '0;
            rsp_q     <= '0;
        end else begin
            grant_q <= '0;
            rsp_q   <= '0;
            unique case (state_q)
                LK_IDLE: begin
                    if (|arb_gnt) begin
                        holder_q  <= arb_idx;
                        op_q      <= aop_e'(req_op[int'(arb_idx)*OP_W +: OP_W]);
                        addr_q    <= req_addr[int'(arb_idx)*ADDR_W +: ADDR_W];
                        operand_q <= req_operand[int'(arb_idx)*DATA_W +: DATA_W];
                        grant_q   <= arb_gnt;
                        state_q   <= LK_READ;
                    end
                end
                LK_READ: begin
                    state_q <= LK_MODIFY;
                end
                LK_MODIFY: begin
                    old_q   <= mem_rdata;
                    carry_q <= alu_carry;
                    sign_q  <= alu_sign;
                    state_q <= LK_DRAIN;
                end
                default: begin
                    if (sb_empty[holder_q]) begin
                        rsp_q   <= NUM_CORES'(1) << holder_q;
                        state_q <= LK_IDLE;
                    end
                end
            endcase
        end
    end

    // Memory port: read in READ, write modified word in MODIFY
    always_comb begin
        mem_rd_en = (state_q == LK_READ);
        mem_wr_en = (state_q == LK_MODIFY);
        mem_addr  = addr_q;
        mem_wdata = alu_new;
    end

    // Per-core stall: everyone but the holder while the lock is taken
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_stall
        assign core_stall[g] = !in_idle && (holder_q != CORE_W'(g));

        // R8
        rsp_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[g] |-> $past(sb_empty[g]) && $past(core_stall[g] == 1'b0));
    end

    // Drive response outputs from the captured result
    always_comb begin
        req_grant = grant_q;
        rsp_valid = rsp_q;
        rsp_old   = old_q;
        rsp_carry = carry_q;
        rsp_sign  = sign_q;
    end

    // R7
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en && $stable(mem_addr) && (req_grant == '0));

    // R6
    stall_during_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> ($countones(core_stall) == NUM_CORES - 1));

    // R5
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

    // R7
    grant_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_grant) |-> mem_rd_en && $onehot(req_grant));

    // R10
    no_grant_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_stall) |=> (req_grant == '0) || $past(|rsp_valid) || (core_stall == '0));
endmodule

// File: tb/test_atomic_lock_unit.sv
`timescale 1ns/1ps
module test_atomic_lock_unit;
    localparam int NC = 3;
    localparam int DW = 16;
    localparam int AW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     req_valid = '0;
    logic [2*NC-1:0]   req_op = '0;
    logic [AW*NC-1:0]  req_addr = '0;
    logic [DW*NC-1:0]  req_operand = '0;
    logic [NC-1:0]     sb_empty = '1;
    logic [NC-1:0]     req_grant, rsp_valid, core_stall;
    logic [DW-1:0]     rsp_old, mem_wdata, mem_rdata;
    logic              rsp_carry, rsp_sign, mem_rd_en, mem_wr_en;
    logic [AW-1:0]     mem_addr;

    int total = 0;
    int fails = 0;
    int gorder[8];
    int glen = 0;

    logic [DW-1:0] mem [16];
    logic          bm_we = 1'b0;
    logic [AW-1:0] bm_a = '0;
    logic [DW-1:0] bm_d = '0;

    always #4 clk = ~clk;

    atomic_lock_unit #(.NUM_CORES(NC), .DATA_W(DW), .ADDR_W(AW)) i_atomic_lock_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_operand(req_operand), .sb_empty(sb_empty),
        .req_grant(req_grant), .rsp_valid(rsp_valid), .rsp_old(rsp_old),
        .rsp_carry(rsp_carry), .rsp_sign(rsp_sign), .core_stall(core_stall),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Bench memory: one-cycle read latency, plus a preload port
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (bm_we) mem[bm_a] <= bm_d;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mem(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk); bm_we = 1'b1; bm_a = a; bm_d = d;
        @(negedge clk); bm_we = 1'b0;
    endtask

    task automatic run_op(int c, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] opnd,
                          output logic [DW-1:0] old, output logic cy, output logic sg);
        @(negedge clk);
        req_op[c*2 +: 2] = op;
        req_addr[c*AW +: AW] = a;
        req_operand[c*DW +: DW] = opnd;
        req_valid[c] = 1'b1;
        do @(negedge clk); while (!req_grant[c]);
        gorder[glen] = c; glen++;
        req_valid[c] = 1'b0;
        do @(negedge clk); while (!rsp_valid[c]);
        old = rsp_old; cy = rsp_carry; sg = rsp_sign;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 grant", 32'(req_grant), 0);
        chk("R11 rsp", 32'(rsp_valid), 0);
        chk("R11 stall", 32'(core_stall), 0);
        chk("R11 mem strobes", {30'd0, mem_rd_en, mem_wr_en}, 0);
    endtask

    task automatic t_bits();
        logic [DW-1:0] o; logic cy, sg;
        set_mem(4'h2, 16'h0000);
        run_op(0, 2'd0, 4'h2, 16'd5, o, cy, sg);
        chk("R1 bts old", 32'(o), 32'h0000);
        chk("R1 bts carry clear", 32'(cy), 0);
        chk("R1 bts write", 32'(mem[2]), 32'h0020);
        run_op(1, 2'd0, 4'h2, 16'd5, o, cy, sg);
        chk("R1 bts carry set", 32'(cy), 1);
        chk("R5 bts old", 32'(o), 32'h0020);
        run_op(2, 2'd0, 4'h2, 16'd15, o, cy, sg);
        chk("R4 bts sign", 32'(sg), 1);
        chk("R1 bts msb write", 32'(mem[2]), 32'h8020);
        run_op(0, 2'd1, 4'h2, 16'd15, o, cy, sg);
        chk("R2 btr carry", 32'(cy), 1);
        chk("R2 btr write", 32'(mem[2]), 32'h0020);
        chk("R4 btr sign", 32'(sg), 0);
        run_op(1, 2'd1, 4'h2, 16'd3, o, cy, sg);
        chk("R2 btr carry clear bit", 32'(cy), 0);
        chk("R2 btr unchanged", 32'(mem[2]), 32'h0020);
    endtask

    task automatic t_dec_xchg();
        logic [DW-1:0] o; logic cy, sg;
        set_mem(4'h7, 16'h0001);
        run_op(1, 2'd2, 4'h7, 16'd0, o, cy, sg);
        chk("R3 dec to zero", 32'(mem[7]), 0);
        chk("R3 dec sign clear", {30'd0, cy, sg}, 0);
        run_op(2, 2'd2, 4'h7, 16'd0, o, cy, sg);
        chk("R3 dec wrap", 32'(mem[7]), 32'hFFFF);
        chk("R3 dec flags carry+sign", {30'd0, cy, sg}, 3);
        chk("R5 dec old", 32'(o), 0);
        run_op(0, 2'd3, 4'h7, 16'h1234, o, cy, sg);
        chk("R4 xchg old", 32'(o), 32'hFFFF);
        chk("R4 xchg write", 32'(mem[7]), 32'h1234);
        chk("R4 xchg flags", {30'd0, cy, sg}, 0);
    endtask

    task automatic t_hold_and_handover();
        logic [DW-1:0] o; logic cy, sg;
        set_mem(4'h3, 16'h0000);
        set_mem(4'h4, 16'h0000);
        @(negedge clk);
        sb_empty[0] = 1'b0;
        req_op[1:0] = 2'd0; req_addr[AW-1:0] = 4'h3; req_operand[DW-1:0] = 16'd0;
        req_valid[0] = 1'b1;
        do @(negedge clk); while (!req_grant[0]);
        req_valid[0] = 1'b0;
        chk("R7 read at grant", {31'd0, mem_rd_en}, 1);
        chk("R6 stall others", 32'(core_stall), 32'b110);
        req_op[3:2] = 2'd3; req_addr[2*AW-1:AW] = 4'h4; req_operand[2*DW-1:DW] = 16'hBEEF;
        req_valid[1] = 1'b1;
        @(negedge clk);
        chk("R7 write next cycle", {30'd0, mem_wr_en, mem_rd_en}, 2);
        chk("R7 write addr", 32'(mem_addr), 3);
        chk("R7 write data", 32'(mem_wdata), 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8 held while buffer busy", 32'(rsp_valid), 0);
            chk("R10 waiter not granted", 32'(req_grant), 0);
            chk("R6 stall kept", 32'(core_stall), 32'b110);
        end
        sb_empty[0] = 1'b1;
        @(negedge clk);
        chk("R8 response after drain", 32'(rsp_valid), 1);
        chk("R6 stall cleared at release", 32'(core_stall), 0);
        chk("R5 carry with pulse", 32'(rsp_carry), 0);
        @(negedge clk);
        chk("R10 waiter granted next", 32'(req_grant), 32'b010);
        chk("R6 owner1 stalls others", 32'(core_stall), 32'b101);
        req_valid[1] = 1'b0;
        do @(negedge clk); while (!rsp_valid[1]);
        chk("R4 waiter xchg done", 32'(mem[4]), 32'hBEEF);
        @(negedge clk);
        chk("R5 pulse one cycle", 32'(rsp_valid), 0);
        o = '0; cy = 1'b0; sg = 1'b0;
    endtask

    task automatic t_round_robin();
        logic [DW-1:0] o; logic cy, sg;
        run_op(1, 2'd3, 4'h9, 16'h0001, o, cy, sg);
        glen = 0;
        fork
            begin logic [DW-1:0] o0; logic c0, s0; run_op(0, 2'd3, 4'hA, 16'h000A, o0, c0, s0); end
            begin logic [DW-1:0] o1; logic c1, s1; run_op(1, 2'd3, 4'hB, 16'h000B, o1, c1, s1); end
            begin logic [DW-1:0] o2; logic c2, s2; run_op(2, 2'd3, 4'hC, 16'h000C, o2, c2, s2); end
        join
        chk("R9 rr first", 32'(gorder[0]), 2);
        chk("R9 rr second", 32'(gorder[1]), 0);
        chk("R9 rr third", 32'(gorder[2]), 1);
        chk("R10 all served", {16'(mem[10]), 16'(mem[12])}, 32'h000A000C);
        run_op(0, 2'd3, 4'h9, 16'h0002, o, cy, sg);
        glen = 0;
        fork
            begin logic [DW-1:0] o0; logic c0, s0; run_op(0, 2'd3, 4'hA, 16'h0000, o0, c0, s0); end
            begin logic [DW-1:0] o2; logic c2, s2; run_op(2, 2'd3, 4'hC, 16'h0000, o2, c2, s2); end
        join
        chk("R9 rr skip idle core", 32'(gorder[0]), 2);
        chk("R9 rr wrap", 32'(gorder[1]), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bits();
        t_dec_xchg();
        t_hold_and_handover();
        t_round_robin();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule